// File: doc/BRIEF.md
# Hysteretic PLL Lock Detector

This block decides whether a phase-locked loop is in lock by watching the up and down correction pulses of its phase/frequency detector. When a loop is locked the correction pulses are very narrow next to the reference period. Out of lock their width sweeps up and down at the difference frequency. The block measures the pulse width of every reference period in system clocks. It classifies the period as narrow or wide against a programmable limit, and feeds the verdict into a saturating digital integrator. This integrator takes the place of an analog capacitor and comparator.

The integrator climbs slowly on narrow periods and falls three times as fast on wide ones. Two separate thresholds give hysteresis, so lock is declared only after a sustained run of narrow periods. A short stretch of phase coincidence while the loop is still acquiring therefore does not produce a false lock. Loss of lock is reported about three times faster than lock is gained. The result drives an active-low lock output.

Top module: `lock_judge`

## Requirements
- R1: While `rstN` is low, and after it rises, `lockN` is high and the integrator is empty. After a reset in the middle of a lock, 23 narrow periods leave `lockN` high and the 24th drives it low.
- R2: A period runs from the cycle after one `refTick` pulse up to and including the next `refTick` cycle. Its width is the number of cycles in which `upPulse`, `downPulse` or both are high, saturating at 255. The period is narrow when width <= `widthLimit` and wide otherwise, so a width equal to the limit counts as narrow.
- R3: A narrow period raises the integrator by 1, saturating at 31. A wide period lowers it by 3, saturating at 0.
- R4: `lockN` goes low one clock after the `refTick` edge that brings the integrator to 24 or above. From an empty integrator, 24 consecutive narrow periods lock and 23 do not.
- R5: `lockN` returns high one clock after the `refTick` edge that brings the integrator to 8 or below. From a saturated integrator, 8 wide periods unlock and 7 do not.
- R6: While the integrator lies between 9 and 23, `lockN` holds its previous value, whether it got there by rising or by falling.
- R7: The integrator changes only on a clock edge where `refTick` is high.
- R8: Repeated bursts of 5 narrow periods, each followed by 2 wide periods, never declare lock from the unlocked state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upPulse | input | 1 | Phase detector up correction pulse |
| downPulse | input | 1 | Phase detector down correction pulse |
| refTick | input | 1 | One-cycle strobe closing each reference period |
| widthLimit | input | 8 | Largest width, in clocks, still judged narrow |
| lockN | output | 1 | Low while the loop is judged locked |

## Verification
The period verdict reaches the integrator on the clock edge that samples `refTick`. `lockN` follows one edge later. The bench therefore drives each 16-cycle period on falling edges and then adds one idle cycle before it samples `lockN` on the next falling edge, which is after both registers have settled. Latency checks count whole periods: the bench samples just before and just after the threshold period (23/24 to lock, 7/8 to unlock, 5/6 on the hysteresis edges). Each check names the period count it expects.

// File: rtl/lock_judge_pkg.sv
package lock_judge_pkg;

  // Strobes from control to datapath, valid in the refTick cycle only
  typedef struct packed {
    logic clearWidth;
    logic stepUp;
    logic stepDown;
  } judge_stb_t;

  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_HELD = 1'b1
  } judge_state_t;

endpackage

// File: rtl/lock_judge_dp.sv
module lock_judge_dp
  import lock_judge_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ACC_W     = 5,
  parameter int UP_STEP   = 1,
  parameter int DOWN_STEP = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upPulse,
  input  logic             downPulse,
  input  judge_stb_t       stb,
  output logic [CNT_W-1:0] periodWidth,
  output logic [ACC_W-1:0] level
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [ACC_W:0]   ACC_TOP  = (ACC_W+1)'((1 << ACC_W) - 1);
  localparam logic [ACC_W:0]   UP_INC   = (ACC_W+1)'(UP_STEP);
  localparam logic [ACC_W:0]   DOWN_DEC = (ACC_W+1)'(DOWN_STEP);

  logic             active;
  logic [CNT_W-1:0] widthCnt;
  logic [ACC_W:0]   raised;
  logic [ACC_W:0]   levelWide;
  logic [ACC_W-1:0] levelNext;

  assign active = upPulse | downPulse;

  // Width including the present cycle, saturating
  always_comb begin
    if (active && (widthCnt != CNT_MAX)) periodWidth = widthCnt + CNT_W'(1);
    else                                 periodWidth = widthCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               widthCnt <= '0;
    else if (stb.clearWidth) widthCnt <= '0;
    else                     widthCnt <= periodWidth;
  end

  assign levelWide = {1'b0, level};
  assign raised    = levelWide + UP_INC;

  always_comb begin
    levelNext = level;
    if (stb.stepUp) begin
      if (raised > ACC_TOP) levelNext = ACC_TOP[ACC_W-1:0];
      else                  levelNext = raised[ACC_W-1:0];
    end else if (stb.stepDown) begin
      if (levelWide < DOWN_DEC) levelNext = '0;
      else                      levelNext = ACC_W'(levelWide - DOWN_DEC);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) level <= '0;
    else       level <= levelNext;
  end

endmodule

// File: rtl/lock_judge_ctl.sv
module lock_judge_ctl
  import lock_judge_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int ACC_W        = 5,
  parameter int LOCK_LEVEL   = 24,
  parameter int UNLOCK_LEVEL = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic [CNT_W-1:0] widthLimit,
  input  logic [CNT_W-1:0] periodWidth,
  input  logic [ACC_W-1:0] level,
  output judge_stb_t       stb,
  output logic             locked
);

  localparam logic [ACC_W-1:0] LOCK_AT   = ACC_W'(LOCK_LEVEL);
  localparam logic [ACC_W-1:0] UNLOCK_AT = ACC_W'(UNLOCK_LEVEL);

  judge_state_t state;
  judge_state_t stateNext;
  logic         narrow;

  assign narrow = (periodWidth <= widthLimit);

  always_comb begin
    stb.clearWidth = refTick;
    stb.stepUp     = refTick & narrow;
    stb.stepDown   = refTick & ~narrow;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_OPEN: if (level >= LOCK_AT)   stateNext = ST_HELD;
      ST_HELD: if (level <= UNLOCK_AT) stateNext = ST_OPEN;
      default: stateNext = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OPEN;
    else       state <= stateNext;
  end

  assign locked = (state == ST_HELD);

endmodule

// File: rtl/lock_judge.sv
module lock_judge
  import lock_judge_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int ACC_W        = 5,
  parameter int UP_STEP      = 1,
  parameter int DOWN_STEP    = 3,
  parameter int LOCK_LEVEL   = 24,
  parameter int UNLOCK_LEVEL = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upPulse,
  input  logic             downPulse,
  input  logic             refTick,
  input  logic [CNT_W-1:0] widthLimit,
  output logic             lockN
);

  judge_stb_t       stb;
  logic [CNT_W-1:0] periodWidth;
  logic [ACC_W-1:0] level;
  logic             locked;

  lock_judge_dp #(
    .CNT_W(CNT_W), .ACC_W(ACC_W), .UP_STEP(UP_STEP), .DOWN_STEP(DOWN_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .upPulse(upPulse), .downPulse(downPulse),
    .stb(stb), .periodWidth(periodWidth), .level(level)
  );

  lock_judge_ctl #(
    .CNT_W(CNT_W), .ACC_W(ACC_W), .LOCK_LEVEL(LOCK_LEVEL), .UNLOCK_LEVEL(UNLOCK_LEVEL)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .widthLimit(widthLimit),
    .periodWidth(periodWidth), .level(level), .stb(stb), .locked(locked)
  );

  assign lockN = ~locked;

endmodule

// File: rtl/lock_judge_chk.sv
module lock_judge_chk #(
  parameter int ACC_W        = 5,
  parameter int UP_STEP      = 1,
  parameter int DOWN_STEP    = 3,
  parameter int LOCK_LEVEL   = 24,
  parameter int UNLOCK_LEVEL = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             refTick,
  input logic [ACC_W-1:0] level,
  input logic             lockN
);

  // R4: lock is entered only once the integrator stood at the top threshold
  assert_lock_at_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockN) |-> (int'($past(level)) >= LOCK_LEVEL));

  // R5: lock is dropped only once the integrator fell to the bottom threshold
  assert_unlock_at_bottom_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockN) |-> (int'($past(level)) <= UNLOCK_LEVEL));

  // R7: the integrator is quiet between reference strobes
  assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(refTick) |-> $stable(level));

  // R3: rising steps are exactly one increment
  assert_rise_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (level > $past(level)) |-> (int'(level) - int'($past(level)) == UP_STEP));

  // R3: falling steps never exceed one decrement
  assert_fall_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (level < $past(level)) |-> (int'($past(level)) - int'(level) <= DOWN_STEP));

endmodule

bind lock_judge lock_judge_chk #(
  .ACC_W(ACC_W), .UP_STEP(UP_STEP), .DOWN_STEP(DOWN_STEP),
  .LOCK_LEVEL(LOCK_LEVEL), .UNLOCK_LEVEL(UNLOCK_LEVEL)
) u_chk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .level(level), .lockN(lockN)
);

// File: tb/tb_lock_judge.sv
module tb_lock_judge;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upPulse = 1'b0;
  logic       downPulse = 1'b0;
  logic       refTick = 1'b0;
  logic [7:0] widthLimit = 8'd3;
  logic       lockN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lock_judge dut (
    .clk(clk), .rstN(rstN), .upPulse(upPulse), .downPulse(downPulse),
    .refTick(refTick), .widthLimit(widthLimit), .lockN(lockN)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (lockN !== exp) begin
      errors++;
      $display("FAIL %s lockN actual %b expected %b", req, lockN, exp);
    end
  endtask

  // mode 0 up only, 1 down only, 2 both together
  task automatic runPeriod(input int width, input int mode);
    for (int i = 0; i < 16; i++) begin
      upPulse   = (mode != 1) && (i >= 1) && (i <= width);
      downPulse = (mode != 0) && (i >= 1) && (i <= width);
      refTick   = (i == 15);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    upPulse = 1'b0; downPulse = 1'b0; refTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 reset held", 1'b1);
    rstN = 1'b1;
    settle();
    check("R1 after reset release", 1'b1);
  endtask

  // R2 boundary width == limit counts narrow; R4 latency 24 periods
  task automatic testLockLatency();
    for (int p = 0; p < 23; p++) runPeriod(3, 0);
    settle();
    check("R4 R2 after 23 narrow periods", 1'b1);
    runPeriod(3, 0);
    settle();
    check("R4 R2 after 24 narrow periods", 1'b0);
  endtask

  // R5 unlock latency from saturation; R2 width limit+1 is wide
  task automatic testUnlockLatency();
    for (int p = 0; p < 10; p++) runPeriod(1, 2);
    settle();
    check("R3 saturated with overlapping pulses", 1'b0);
    for (int p = 0; p < 7; p++) runPeriod(4, p % 2);
    settle();
    check("R5 R2 after 7 wide periods", 1'b0);
    runPeriod(4, 1);
    settle();
    check("R5 R2 after 8 wide periods", 1'b1);
  endtask

  // R6 hysteresis in both directions; level starts at 7
  task automatic testHysteresis();
    for (int p = 0; p < 16; p++) runPeriod(2, 1);
    settle();
    check("R6 level 23 still unlocked", 1'b1);
    runPeriod(2, 1);
    settle();
    check("R4 level 24 locks", 1'b0);
    for (int p = 0; p < 5; p++) runPeriod(12, 0);
    settle();
    check("R6 level 9 still locked", 1'b0);
    runPeriod(12, 0);
    settle();
    check("R5 level 6 unlocks", 1'b1);
  endtask

  // R8 short coincidences never lock
  task automatic testCoincidence();
    for (int r = 0; r < 20; r++) begin
      for (int p = 0; p < 5; p++) runPeriod(1, 0);
      runPeriod(10, 1);
      runPeriod(10, 0);
      settle();
      check("R8 coincidence burst", 1'b1);
    end
  endtask

  // R1 mid-lock reset clears the integrator
  task automatic testMidReset();
    for (int p = 0; p < 24; p++) runPeriod(3, 2);
    settle();
    check("R4 relock from empty", 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset while locked", 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 23; p++) runPeriod(3, 0);
    settle();
    check("R1 integrator cleared, 23 narrow", 1'b1);
    runPeriod(3, 0);
    settle();
    check("R1 integrator cleared, 24 narrow", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLockLatency();
    testUnlockLatency();
    testHysteresis();
    testCoincidence();
    testMidReset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule